// File: doc/BRIEF.md
# Descriptor-chain DMA sequencer

This block drives a data mover through a list of buffers. Each buffer is described by a three-word descriptor: a link word, a buffer start address and a buffer length in bytes. Software loads the first descriptor straight into registers, sets the list base address and then writes the control word. The sequencer checks the alignment of the current buffer and asks the data mover for one transfer. When the mover reports completion, the sequencer reads the next descriptor through a simple word-read port and repeats. The link word gives the offset of the next descriptor relative to the list base. A link word whose continue flag is clear ends the chain. After the last transfer the block gives a one-cycle completion pulse and goes idle.

A single-buffer mode uses only the start address and length registers and stops after one transfer. A control write with the run bit clear aborts any activity. The link word carries two further flags. One decides whether the next descriptor's length replaces the current length. The other is passed to the data mover as a bus-request hint.

Top module: `lldma_seq`

## Requirements
- R1: After reset, busy, done, align_err, xfer_req and mem_req are all 0.
- R2: Register map on reg_addr: 0 list base, 1 link word, 2 buffer start, 3 buffer length, 4 control (bit 0 run, bit 1 list mode). A control write with run=1 while idle starts the engine.
- R3: In single-buffer mode (control bit 1 = 0), exactly one transfer is requested with the buffer start and length registers, whatever the link word holds.
- R4: In list mode, the first transfer uses the registers. After each xfer_done whose link word has bit 31 (continue) set, three words are read at list_base + {link[15:2],2'b00} + 0, +4 and +8. These are taken in order as the next link word, buffer start and length.
- R5: When the current link word has bit 30 (length update) clear, the fetched length word is discarded and the previous length is reused for the next transfer.
- R6: xfer_bus_req follows bit 29 of the current link word during a list-mode transfer, and is 0 in single-buffer mode.
- R7: A buffer start address whose bits [1:0] are not zero sets align_err and returns the block to idle without requesting that transfer.
- R8: A length that is not a multiple of BURST sets align_err when the descriptor has bit 31 set. The length of the final descriptor, and of a single buffer, is not constrained.
- R9: done pulses for exactly one cycle, one cycle after the xfer_done of the final transfer, and the block is then idle.
- R10: A control write with bit 0 clear stops the engine at once. It drops xfer_req and busy and produces no done pulse.
- R11: Writes to registers 0 to 3 while busy are ignored. Control writes with run=1 while busy are ignored.
- R12: align_err stays set until the next control write, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the descriptor word |
| mem_ack | input | 1 | Read acknowledge, with data valid in the same cycle |
| mem_rdata | input | 32 | Descriptor word read data |
| xfer_req | output | 1 | Transfer request to the data mover, held until xfer_done |
| xfer_addr | output | AW | Buffer start address of the current transfer |
| xfer_size | output | SIZE_W | Buffer length of the current transfer in bytes |
| xfer_bus_req | output | 1 | Bus-request hint taken from the link word |
| xfer_done | input | 1 | Completion pulse from the data mover |
| busy | output | 1 | Engine is active |
| done | output | 1 | One-cycle end-of-chain pulse |
| align_err | output | 1 | Sticky alignment error |

## Verification
The hardest state to reach from the ports is an alignment failure partway through a chain. This is a descriptor that arrives by fetch rather than by register write, after an earlier transfer has already completed. A directed chain places an unaligned start address in its second descriptor so that exactly one transfer happens before the error. Random chains of one to five descriptors mix cleared length-update flags, random bus-request flags, random mover latencies and unaligned final lengths. The bench compares every issued transfer against sizes it derives itself. Stopping during a held transfer and writing registers while busy are covered by holding xfer_done off indefinitely.

// File: rtl/lldma_seq.sv
module lldma_seq #(
  parameter int AW     = 32,
  parameter int SIZE_W = 16,
  parameter int BURST  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [AW-1:0]     xfer_addr,
  output logic [SIZE_W-1:0] xfer_size,
  output logic              xfer_bus_req,
  input  logic              xfer_done,
  output logic              busy,
  output logic              done,
  output logic              align_err
);
  localparam int CONT_B = 31;
  localparam int LEN_B  = 30;
  localparam int BUS_B  = 29;
  localparam logic [SIZE_W-1:0] BMASK = SIZE_W'(BURST - 1);
  localparam logic [2:0] A_LIST = 3'd0, A_LINK = 3'd1, A_BASE = 3'd2,
                         A_SIZE = 3'd3, A_CTRL = 3'd4;

  typedef enum logic [1:0] {IDLE, CHK, XFER, FETCH} st_t;
  st_t state;

  logic [AW-1:0]     list_base, base_r;
  logic [31:0]       link_r, nxt_link;
  logic [SIZE_W-1:0] size_r;
  logic              list_mode, done_r, err_r;
  logic [1:0]        idx;

  wire ctrl_wr = reg_we && reg_addr == A_CTRL;
  wire more    = list_mode && link_r[CONT_B];
  wire bad     = base_r[1:0] != 2'b00 || (more && (size_r & BMASK) != '0);

  assign busy         = state != IDLE;
  assign done         = done_r;
  assign align_err    = err_r;
  assign xfer_req     = state == XFER;
  assign xfer_addr    = base_r;
  assign xfer_size    = size_r;
  assign xfer_bus_req = list_mode && link_r[BUS_B];
  assign mem_req      = state == FETCH;
  assign mem_addr     = list_base + AW'({link_r[15:2], 2'b00}) + AW'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      list_base <= '0;
      base_r    <= '0;
      link_r    <= '0;
      nxt_link  <= '0;
      size_r    <= '0;
      list_mode <= 1'b0;
      done_r    <= 1'b0;
      err_r     <= 1'b0;
      idx       <= '0;
    end else begin
      done_r <= 1'b0;
      if (ctrl_wr) begin
        err_r <= 1'b0;
        if (!reg_wdata[0]) state <= IDLE;
        else if (state == IDLE) begin
          list_mode <= reg_wdata[1];
          state     <= CHK;
        end
      end else begin
        case (state)
          CHK: begin
            if (bad) begin
              err_r <= 1'b1;
              state <= IDLE;
            end else state <= XFER;
          end
          XFER: if (xfer_done) begin
            if (more) begin
              idx   <= '0;
              state <= FETCH;
            end else begin
              done_r <= 1'b1;
              state  <= IDLE;
            end
          end
          FETCH: if (mem_ack) begin
            idx <= idx + 2'd1;
            case (idx)
              2'd0: nxt_link <= mem_rdata;
              2'd1: base_r   <= AW'(mem_rdata);
              default: begin
                if (link_r[LEN_B]) size_r <= mem_rdata[SIZE_W-1:0];
                link_r <= nxt_link;
                state  <= CHK;
              end
            endcase
          end
          default: ;
        endcase
        if (reg_we && state == IDLE) begin
          case (reg_addr)
            A_LIST: list_base <= AW'(reg_wdata);
            A_LINK: link_r    <= reg_wdata;
            A_BASE: base_r    <= AW'(reg_wdata);
            A_SIZE: size_r    <= reg_wdata[SIZE_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_done) && !busy); // R9
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done && !ctrl_wr |=> xfer_req && $stable(xfer_addr) && $stable(xfer_size)); // R11
  AST_XFER_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_addr[1:0] == 2'b00); // R7
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_err) |-> !xfer_req && !busy); // R7
  AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !reg_wdata[0] |=> !busy && !xfer_req && !done); // R10
  AST_FETCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !ctrl_wr |=> mem_req && $stable(mem_addr)); // R4
endmodule

// File: tb/sim_lldma_seq.sv
`timescale 1ns/1ps
module sim_lldma_seq;
  localparam int AW = 32, SW = 16, BURST = 16;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic xfer_req, xfer_bus_req, xfer_done = 0, busy, done, align_err;
  logic [AW-1:0] xfer_addr;
  logic [SW-1:0] xfer_size;

  lldma_seq #(.AW(AW), .SIZE_W(SW), .BURST(BURST)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_size(xfer_size),
    .xfer_bus_req(xfer_bus_req), .xfer_done(xfer_done),
    .busy(busy), .done(done), .align_err(align_err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, lat = 1, xcnt = 0, dcount = 0, lg_n = 0;
  logic [31:0] mem [0:63];
  logic [AW-1:0] lg_addr [0:15];
  logic [SW-1:0] lg_size [0:15];
  logic lg_abr [0:15];

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (xfer_req && !xfer_done) begin
      xcnt = xcnt + 1;
      if (xcnt >= lat) begin
        xfer_done <= 1'b1;
        xcnt = 0;
        if (lg_n < 16) begin
          lg_addr[lg_n] = xfer_addr;
          lg_size[lg_n] = xfer_size;
          lg_abr[lg_n]  = xfer_bus_req;
        end
        lg_n = lg_n + 1;
      end
    end else begin
      xfer_done <= 1'b0;
      if (!xfer_req) xcnt = 0;
    end
    if (done) dcount = dcount + 1;
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [SW-1:0] next_size(bit take, logic [SW-1:0] fetched, logic [SW-1:0] prev);
    return take ? fetched : prev;
  endfunction

  function automatic logic [31:0] mk_link(int i, bit cont, bit uls, bit abr);
    return 32'((i + 1) * 12) | (cont ? 32'h8000_0000 : 0) | (uls ? 32'h4000_0000 : 0)
           | (abr ? 32'h2000_0000 : 0);
  endfunction

  initial begin
    logic [31:0] lk [0:4];
    logic [31:0] bs [0:4];
    logic [SW-1:0] sz [0:4];
    logic [SW-1:0] es;
    bit uls [0:4];
    bit abr [0:4];
    int n, lb, d0;
    void'($urandom(1234));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !align_err && !xfer_req && !mem_req, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // single mode, link says continue but must be ignored
    lg_n = 0; d0 = dcount; lat = 2;
    wr(1, 32'hE000_000C); wr(2, 32'h0000_1233 & ~32'h3); wr(3, 32'd7); wr(4, 32'h1);
    wait_idle();
    chk(lg_n == 1, "R3 single count", lg_n, 1);
    chk(lg_addr[0] == 32'h1230 && lg_size[0] == 7, "R3 single data", lg_addr[0], 32'h1230);
    chk(lg_abr[0] == 0, "R6 single bus hint", lg_abr[0], 0);
    chk(dcount == d0 + 1, "R9 done single", dcount - d0, 1);

    // unaligned base
    lg_n = 0; d0 = dcount;
    wr(2, 32'h102); wr(3, 32'd16); wr(4, 32'h1);
    wait_idle();
    chk(align_err && lg_n == 0 && dcount == d0, "R7 base align", lg_n, 0);
    wr(4, 32'h0);
    chk(!align_err, "R12 clear", align_err, 0);

    // non-last size unaligned in list mode
    lg_n = 0;
    wr(0, 32'h0); wr(1, mk_link(0, 1, 1, 0)); wr(2, 32'h200); wr(3, 32'd20); wr(4, 32'h3);
    wait_idle();
    chk(align_err && lg_n == 0, "R8 size align", lg_n, 0);
    wr(4, 32'h1);
    wait_idle();
    chk(!align_err && lg_n == 1, "R12 clear on start", align_err, 0);

    // error in fetched second descriptor
    lg_n = 0; d0 = dcount;
    mem[3] = mk_link(1, 0, 1, 0); mem[4] = 32'h301; mem[5] = 32'd32;
    wr(0, 32'h0); wr(1, mk_link(0, 1, 1, 0)); wr(2, 32'h200); wr(3, 32'd32); wr(4, 32'h3);
    wait_idle();
    chk(lg_n == 1 && align_err && dcount == d0, "R7 mid-chain error", lg_n, 1);

    // stop during held transfer, writes while busy ignored
    lg_n = 0; d0 = dcount; lat = 1000000;
    wr(2, 32'h400); wr(3, 32'd64); wr(4, 32'h1);
    repeat (3) @(negedge clk);
    chk(xfer_req && xfer_addr == 32'h400, "R3 held req", xfer_addr, 32'h400);
    wr(2, 32'h800); wr(3, 32'd4); wr(4, 32'h3);
    chk(xfer_addr == 32'h400 && xfer_size == 64, "R11 busy writes ignored", xfer_addr, 32'h400);
    wr(4, 32'h0);
    chk(!xfer_req && !busy, "R10 stop", xfer_req, 0);
    repeat (3) @(negedge clk);
    chk(dcount == d0 && lg_n == 0, "R10 no done", dcount - d0, 0);

    // random chains
    for (int t = 0; t < 40; t++) begin
      n = 1 + $urandom % 5;
      lb = 4 * ($urandom % 8);
      lat = 1 + $urandom % 4;
      for (int i = 0; i < n; i++) begin
        uls[i] = $urandom % 2; abr[i] = $urandom % 2;
        bs[i] = $urandom & 32'hFFFF_FFFC;
        sz[i] = (i == n - 1) ? SW'(1 + $urandom % 200) : SW'(16 * (1 + $urandom % 8));
        lk[i] = mk_link(i, i < n - 1, uls[i], abr[i]);
        mem[lb / 4 + 3 * i] = lk[i]; mem[lb / 4 + 3 * i + 1] = bs[i]; mem[lb / 4 + 3 * i + 2] = 32'(sz[i]);
      end
      lg_n = 0; d0 = dcount;
      wr(0, 32'(lb)); wr(1, lk[0]); wr(2, bs[0]); wr(3, 32'(sz[0])); wr(4, 32'h3);
      wait_idle();
      chk(lg_n == n, "R4 chain length", lg_n, n);
      chk(dcount == d0 + 1 && !align_err, "R9 chain done", dcount - d0, 1);
      es = sz[0];
      for (int i = 0; i < n && i < lg_n; i++) begin
        if (i > 0) es = next_size(uls[i - 1], sz[i], es);
        chk(lg_addr[i] == bs[i], "R4 fetched base", lg_addr[i], bs[i]);
        chk(lg_size[i] == es, "R5 size reuse", lg_size[i], es);
        chk(lg_abr[i] == abr[i], "R6 bus hint", lg_abr[i], abr[i]);
      end
    end
    chk(!busy, "R2 idle at end", busy, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule